// File: doc/BRIEF.md
# Impact Printer Actuator Output Latches

This block holds the actuator patterns of an impact printer: a nine-pin printhead pattern, a four-phase paper-feed stepper pattern and a four-phase carriage stepper pattern. The CPU stores each pattern by writing to that latch's own register address. The same address returns the stored value for read-back. The stored patterns drive the motor phase outputs directly. The head pattern reaches the solenoid outputs only while the CPU holds the active-low fire strobe low, so the CPU sets the length of each firing pulse.

Two inputs bring the outputs to a safe state. The active-low initialise input works synchronously. While it is low, the head outputs switch off at once, even with fire asserted. At the next clock edge the head and feed latches are cleared and the carriage latch is set to all ones. The active-low chip reset applies the same latch values asynchronously. Its release is synchronised, so the latches start accepting writes on the third rising edge after reset goes high.

Top module: `actuator_latch_bank`

## Requirements
- R1: A write with `addr` = 0 loads all nine bits of `wr_data` into the head latch at the next rising edge, and `rd_data` at `addr` = 0 then returns that value.
- R2: While `fire_n` is high every bit of `head_o` is low. While `fire_n` is low and `init_n` is high, `head_o` equals the head latch.
- R3: While `init_n` is low, `head_o` is all zero in the same cycle even with `fire_n` low, and the head latch is cleared at the next rising edge.
- R4: `init_n` low at a rising edge clears the paper-feed latch, so `pf_o` becomes 4'h0.
- R5: `init_n` low at a rising edge sets the carriage latch, so `cr_o` becomes 4'hF.
- R6: While `rst_n` is low the outputs are at once head 0, feed 4'h0, carriage 4'hF. After `rst_n` rises, writes on the first two rising edges are ignored and the third edge accepts a write.
- R7: A write with `addr` = 1 loads `wr_data[3:0]` into the feed latch, and one with `addr` = 2 loads it into the carriage latch. Each of these reads back at its own address, zero-extended. A latch that is not addressed keeps its value.
- R8: A write with `addr` = 3 changes no latch, and a read at `addr` = 3 returns 0.
- R9: A head write made while `fire_n` is low shows on `head_o` straight after the rising edge that stores it.
- R10: When `init_n` is low, a write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| init_n | input | 1 | Active-low initialise, synchronous |
| fire_n | input | 1 | Active-low head fire strobe |
| wr_en | input | 1 | Write enable |
| addr | input | 2 | Register address: 0 head, 1 feed, 2 carriage, 3 spare |
| wr_data | input | 9 | Write data |
| rd_data | output | 9 | Read-back of the addressed latch |
| head_o | output | 9 | Printhead solenoid outputs, high = energise |
| pf_o | output | 4 | Paper-feed stepper phases |
| cr_o | output | 4 | Carriage stepper phases |

## Verification
The latch contents and the motor outputs change one rising edge after the write or initialise cycle. `rd_data` follows `addr` without a clock, and `head_o` follows `fire_n` and `init_n` without a clock. Writes take effect only from the third rising edge after `rst_n` rises. The bench changes its inputs on falling edges and works out the expected outputs for the next rising edge from a reference model, including the reset-release count. A monitor then compares those expected values 1 ns after that edge, once the registers and the combinational gating have both settled.

// File: rtl/alb_pkg.sv
package alb_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_HEAD  = 2'd0,
    SEL_FEED  = 2'd1,
    SEL_CARR  = 2'd2,
    SEL_SPARE = 2'd3
  } sel_e;
endpackage

// File: rtl/alb_rst_sync.sv
module alb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alb_latch.sv
module alb_latch #(
  parameter int unsigned W         = 4,
  parameter logic [W-1:0] SAFE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | ld;
    q_d  = clr ? SAFE_VAL : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SAFE_VAL;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/alb_head_gate.sv
module alb_head_gate #(
  parameter int unsigned W = 9
) (
  input  logic         fire_n,
  input  logic         init_n,
  input  logic [W-1:0] pattern,
  output logic [W-1:0] pins
);
  logic pass;

  always_comb begin
    pass = ~fire_n & init_n;
    pins = pattern & {W{pass}};
  end
endmodule

// File: rtl/actuator_latch_bank.sv
module actuator_latch_bank #(
  parameter int unsigned HEAD_W  = 9,
  parameter int unsigned MOTOR_W = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init_n,
  input  logic                      fire_n,
  input  logic                      wr_en,
  input  logic [alb_pkg::ADDR_W-1:0] addr,
  input  logic [HEAD_W-1:0]         wr_data,
  output logic [HEAD_W-1:0]         rd_data,
  output logic [HEAD_W-1:0]         head_o,
  output logic [MOTOR_W-1:0]        pf_o,
  output logic [MOTOR_W-1:0]        cr_o
);
  import alb_pkg::*;

  localparam int unsigned PAD_W = HEAD_W - MOTOR_W;
  localparam int unsigned N_LATCH = 3;

  logic              rst_sync_n;
  sel_e              sel;
  logic              clr;
  logic [N_LATCH-1:0] ld;
  logic [HEAD_W-1:0] head_q;

  alb_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel = sel_e'(addr);
    clr = ~init_n;
    for (int i = 0; i < N_LATCH; i++) begin
      ld[i] = wr_en & init_n & (addr == i[ADDR_W-1:0]);
    end
  end

  alb_latch #(.W(HEAD_W), .SAFE_VAL('0)) u_head (
    .clk (clk), .rst_n (rst_sync_n), .clr (clr), .ld (ld[SEL_HEAD]),
    .d (wr_data), .q (head_q)
  );

  alb_latch #(.W(MOTOR_W), .SAFE_VAL('0)) u_feed (
    .clk (clk), .rst_n (rst_sync_n), .clr (clr), .ld (ld[SEL_FEED]),
    .d (wr_data[MOTOR_W-1:0]), .q (pf_o)
  );

  alb_latch #(.W(MOTOR_W), .SAFE_VAL({MOTOR_W{1'b1}})) u_carr (
    .clk (clk), .rst_n (rst_sync_n), .clr (clr), .ld (ld[SEL_CARR]),
    .d (wr_data[MOTOR_W-1:0]), .q (cr_o)
  );

  alb_head_gate #(.W(HEAD_W)) u_gate (
    .fire_n (fire_n), .init_n (init_n), .pattern (head_q), .pins (head_o)
  );

  always_comb begin
    case (sel)
      SEL_HEAD: rd_data = head_q;
      SEL_FEED: rd_data = {{PAD_W{1'b0}}, pf_o};
      SEL_CARR: rd_data = {{PAD_W{1'b0}}, cr_o};
      default:  rd_data = '0;
    endcase
  end

  assert_head_load_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == SEL_HEAD && init_n) |=> (head_q == $past(wr_data)));

  assert_fire_off_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fire_n |-> (head_o == '0));

  assert_fire_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fire_n && init_n) |-> (head_o == head_q));

  assert_init_head_off_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !init_n |-> (head_o == '0));

  assert_init_feed_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !init_n |=> (pf_o == '0));

  assert_init_carr_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !init_n |=> (cr_o == {MOTOR_W{1'b1}}));

  assert_feed_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_n && !(wr_en && addr == SEL_FEED)) |=> $stable(pf_o));

  assert_spare_ignored_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_n && wr_en && addr == SEL_SPARE) |=>
      ($stable(head_q) && $stable(pf_o) && $stable(cr_o)));
endmodule

// File: tb/actuator_latch_bank_tb_top.sv
module actuator_latch_bank_tb_top;
  typedef struct {
    logic [8:0] head;
    logic [3:0] pf;
    logic [3:0] cr;
    logic [8:0] rd;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n, init_n, fire_n, wr_en;
  logic [1:0] addr;
  logic [8:0] wr_data;
  logic [8:0] rd_data, head_o;
  logic [3:0] pf_o, cr_o;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [8:0] m_head;
  logic [3:0] m_pf, m_cr;
  int         rel_cnt;

  always #2 clk = ~clk;

  actuator_latch_bank dut_i (
    .clk (clk), .rst_n (rst_n), .init_n (init_n), .fire_n (fire_n),
    .wr_en (wr_en), .addr (addr), .wr_data (wr_data), .rd_data (rd_data),
    .head_o (head_o), .pf_o (pf_o), .cr_o (cr_o)
  );

  task automatic cyc(input bit rst, input bit init, input bit fire,
                     input bit wr, input logic [1:0] a, input logic [8:0] d,
                     input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; init_n = init; fire_n = fire; wr_en = wr; addr = a; wr_data = d;
    if (!rst) begin
      rel_cnt = 0; m_head = '0; m_pf = '0; m_cr = 4'hF;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else if (!init) begin
      m_head = '0; m_pf = '0; m_cr = 4'hF;
    end else if (wr) begin
      case (a)
        2'd0: m_head = d;
        2'd1: m_pf = d[3:0];
        2'd2: m_cr = d[3:0];
        default: ;
      endcase
    end
    e.head = (!fire && init) ? m_head : 9'h0;
    e.pf = m_pf;
    e.cr = m_cr;
    case (a)
      2'd0: e.rd = m_head;
      2'd1: e.rd = {5'h0, m_pf};
      2'd2: e.rd = {5'h0, m_cr};
      default: e.rd = 9'h0;
    endcase
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (head_o !== e.head || pf_o !== e.pf || cr_o !== e.cr || rd_data !== e.rd) begin
          errors++;
          $display("FAIL %s: actual head=%h pf=%h cr=%h rd=%h expected head=%h pf=%h cr=%h rd=%h",
                   e.tag, head_o, pf_o, cr_o, rd_data, e.head, e.pf, e.cr, e.rd);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; init_n = 1; fire_n = 1; wr_en = 0; addr = 0; wr_data = 0;
    rel_cnt = 0; m_head = '0; m_pf = '0; m_cr = 4'hF;
    // R6: reset state, then writes ignored during synchronised release
    cyc(0, 1, 0, 1, 2'd0, 9'h1FF, "R6 reset state");
    cyc(0, 1, 1, 0, 2'd2, 9'h000, "R6 reset carriage read");
    cyc(1, 1, 0, 1, 2'd0, 9'h1AB, "R6 release edge 1 ignores write");
    cyc(1, 1, 0, 1, 2'd1, 9'h00C, "R6 release edge 2 ignores write");
    cyc(1, 1, 1, 1, 2'd0, 9'h155, "R6 third edge accepts write");
    // R1 / R2: load with fire high, outputs held low
    cyc(1, 1, 1, 0, 2'd0, 9'h000, "R1 readback, R2 fire high off");
    cyc(1, 1, 0, 0, 2'd0, 9'h000, "R2 fire low passes pattern");
    cyc(1, 1, 0, 1, 2'd0, 9'h0F3, "R9 write while firing");
    cyc(1, 1, 1, 0, 2'd0, 9'h000, "R2 fire released");
    // R7 motor latches
    cyc(1, 1, 1, 1, 2'd1, 9'h1E5, "R7 feed write");
    cyc(1, 1, 1, 1, 2'd2, 9'h00A, "R7 carriage write");
    cyc(1, 1, 0, 0, 2'd1, 9'h000, "R7 feed readback head kept");
    cyc(1, 1, 1, 0, 2'd2, 9'h000, "R7 carriage readback");
    // R8 spare address
    cyc(1, 1, 1, 1, 2'd3, 9'h1FF, "R8 spare write ignored");
    cyc(1, 1, 0, 0, 2'd3, 9'h000, "R8 spare reads zero");
    cyc(1, 1, 0, 0, 2'd0, 9'h000, "R8 head unchanged");
    // R3/R4/R5/R10 initialise with fire low and concurrent write
    cyc(1, 0, 0, 1, 2'd0, 9'h1FF, "R3 R4 R5 R10 init overrides");
    cyc(1, 0, 0, 1, 2'd2, 9'h003, "R5 R10 init holds carriage");
    cyc(1, 1, 0, 0, 2'd0, 9'h000, "R3 head latch cleared");
    cyc(1, 1, 0, 0, 2'd1, 9'h000, "R4 feed cleared");
    // R6 asynchronous reset mid-run
    cyc(1, 1, 0, 1, 2'd0, 9'h1C7, "R1 reload");
    cyc(1, 1, 0, 1, 2'd1, 9'h009, "R7 feed reload");
    cyc(0, 1, 0, 0, 2'd0, 9'h000, "R6 async reset head");
    cyc(0, 1, 0, 0, 2'd1, 9'h000, "R6 async reset feed");
    cyc(1, 1, 0, 0, 2'd2, 9'h000, "R6 carriage after reset");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule